// File: doc/BRIEF.md
# Program Memory Table Read Unit

This unit carries out the table-read instructions of a small microcontroller core. It fetches one constant word from program memory and splits it in two. The program memory address is built from an 8-bit table pointer and three page bits. Those page bits come from one of two places. They are either the page the program counter is on now, or they are forced to ones so that the read lands on the last page. The low byte of the fetched word goes out on a data memory write port to a destination named with the request. The high byte is held in a table-high register. Software can read that register but has no path to write it.

The instruction decoder issues a request with a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the decoder must hold its request or drop it; a request shown in that cycle is not taken. The table pointer and the program counter are sampled on the edge that takes the request. The table pointer must therefore already hold its new value in that cycle.

Every read takes two cycles after it is taken:
- **Fetch cycle:** the program memory read is issued and `busy` is high, so the core holds back its next fetch.
- **Write cycle:** the synchronous memory returns the word, the low byte is written out, and the table-high register is loaded on the closing edge. A new request may be taken in this cycle.

Top module: `tblrd_unit`

## Requirements
- R1: When a request is taken with `req_mode`=0 (current page), the fetch cycle drives `pm_addr` = {`pc`[10:8], `tblp`[7:0]}, using the values present on the edge that took the request.
- R2: When a request is taken with `req_mode`=1 (last page), the fetch cycle drives `pm_addr` = {3'b111, `tblp`[7:0]}.
- R3: In the cycle right after a request is taken, `pm_rd_en` and `busy` are both high, and `req_ready` is low. In every other cycle, `pm_rd_en` and `busy` are low.
- R4: In the cycle after the fetch cycle, `dm_we` is high for exactly one cycle. In that cycle `dm_addr` equals the request's `req_dest` and `dm_wdata` equals bits 7:0 of the word read.
- R5: On the edge that closes the write cycle, `tblh` takes bits 15:8 of the word read. The new value is visible from the next cycle on.
- R6: `tblh` keeps its value in every cycle that does not close a write cycle. A request shown while `req_ready` is low is ignored: it causes no fetch, no write and no `tblh` change.
- R7: After reset, `busy`, `pm_rd_en` and `dm_we` are 0, `req_ready` is 1, and `tblh` is 0.
- R8: A request taken during a write cycle starts its fetch cycle on the very next cycle. Back-to-back reads therefore complete one every two cycles.
- R9: Changes to `tblp`, `pc`, `req_mode` or `req_dest` after the edge that took the request have no effect on that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Table-read request strobe |
| req_ready | output | 1 | High when a request can be taken |
| req_mode | input | 1 | 0 = current page, 1 = last page |
| req_dest | input | 7 | Data memory destination for the low byte |
| tblp | input | 8 | Table pointer register value |
| pc | input | 11 | Current program counter |
| pm_rd_en | output | 1 | Program memory read enable |
| pm_addr | output | 11 | Program memory address |
| pm_rdata | input | 16 | Program memory word, valid the cycle after `pm_rd_en` |
| dm_we | output | 1 | Data memory write enable |
| dm_addr | output | 7 | Data memory write address |
| dm_wdata | output | 8 | Data memory write data (low byte) |
| busy | output | 1 | Stall for the next instruction fetch |
| tblh | output | 8 | Read-only table-high register |

## Verification
The hardest case is a request taken in the same cycle that the previous read writes its low byte. In that cycle the old word's bytes must still reach `dm_wdata` and `tblh`, while the new address is captured.

The stimulus reaches it in two ways. Directed runs hold `req_valid` high through whole sequences. Pseudo-random runs also change `tblp`, `pc` and `req_dest` in the fetch cycle, and show requests while the unit is busy.

A behavioural model predicts every output on every cycle, so any overlap or ignored-request error shows up as a miscompare.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WRITE = 2'd2
  } tblrd_state_e;
endpackage

// File: rtl/tblrd_addr.sv
module tblrd_addr #(
  parameter int PA_W = 11,
  parameter int TP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic            last_page,
  input  logic [TP_W-1:0] tblp,
  input  logic [PA_W-1:0] pc,
  output logic [PA_W-1:0] addr_q
);
  localparam int PG_W = PA_W - TP_W;

  logic [PG_W-1:0] page_sel;

  genvar gi;
  generate
    for (gi = 0; gi < PG_W; gi++) begin : g_page
      assign page_sel[gi] = last_page | pc[TP_W+gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else if (capture) addr_q <= {page_sel, tblp};
  end

  // R9: the captured address stays put unless a new request is captured
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(addr_q));
  // R2: a last-page capture lands on the all-ones page
  p_last_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && last_page) |=> (&addr_q[PA_W-1:TP_W]));
endmodule

// File: rtl/tblrd_seq.sv
module tblrd_seq
  import tblrd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic accept,
  output logic in_fetch,
  output logic in_write
);
  tblrd_state_e st_q, st_d;

  assign req_ready = (st_q != ST_FETCH);
  assign accept    = req_valid && req_ready;
  assign in_fetch  = (st_q == ST_FETCH);
  assign in_write  = (st_q == ST_WRITE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = ST_FETCH;
      ST_FETCH: st_d = ST_WRITE;
      ST_WRITE: st_d = accept ? ST_FETCH : ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // R4: a fetch cycle is always followed by a write cycle
  p_fetch_then_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_fetch |=> in_write);
  // R3: a taken request opens a fetch cycle
  p_accept_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> in_fetch);
  // R6: a request shown while not ready is not taken
  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_fetch |=> !in_fetch);
endmodule

// File: rtl/tblrd_hreg.sv
module tblrd_hreg #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] din,
  output logic [BW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end

  // R6: the table-high value only moves on a write-cycle load
  p_tblh_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
  // R5: a load makes the byte visible on the next cycle
  p_tblh_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(din)));
endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit #(
  parameter int PA_W = 11,
  parameter int TP_W = 8,
  parameter int DW   = 16,
  parameter int DA_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_mode,
  input  logic [DA_W-1:0] req_dest,
  input  logic [TP_W-1:0] tblp,
  input  logic [PA_W-1:0] pc,
  output logic            pm_rd_en,
  output logic [PA_W-1:0] pm_addr,
  input  logic [DW-1:0]   pm_rdata,
  output logic            dm_we,
  output logic [DA_W-1:0] dm_addr,
  output logic [DW/2-1:0] dm_wdata,
  output logic            busy,
  output logic [DW/2-1:0] tblh
);
  localparam int BW = DW / 2;

  logic            accept, in_fetch, in_write;
  logic [PA_W-1:0] addr_q;
  logic [DA_W-1:0] dest_q;

  tblrd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .accept(accept), .in_fetch(in_fetch), .in_write(in_write)
  );

  tblrd_addr #(.PA_W(PA_W), .TP_W(TP_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .capture(accept), .last_page(req_mode),
    .tblp(tblp), .pc(pc), .addr_q(addr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      dest_q <= '0;
    else if (accept) dest_q <= req_dest;
  end

  tblrd_hreg #(.BW(BW)) u_hreg (
    .clk(clk), .rst_n(rst_n), .load(in_write),
    .din(pm_rdata[DW-1:BW]), .q(tblh)
  );

  assign busy     = in_fetch;
  assign pm_rd_en = in_fetch;
  assign pm_addr  = in_fetch ? addr_q : '0;
  assign dm_we    = in_write;
  assign dm_addr  = in_write ? dest_q : '0;
  assign dm_wdata = in_write ? pm_rdata[BW-1:0] : '0;

  // R4: one write strobe per read, never two in a row
  p_single_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |=> !dm_we);
  // R3: busy never coexists with ready
  p_busy_not_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  // R4: the write cycle follows a read issue
  p_write_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rd_en |=> dm_we);
endmodule

// File: tb/tblrd_unit_tb_top.sv
module tblrd_unit_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_mode = 0;
  logic [6:0]  req_dest = 0;
  logic [7:0]  tblp = 0;
  logic [10:0] pc = 0;
  logic [15:0] pm_rdata = 0;
  logic        req_ready, pm_rd_en, dm_we, busy;
  logic [10:0] pm_addr;
  logic [6:0]  dm_addr;
  logic [7:0]  dm_wdata, tblh;

  int vectors = 0, errors = 0;
  int m_st = 0;
  int m_addr = 0, m_dest = 0, m_tblh = 0;
  int seed = 32'h1234567;
  bit done = 0;

  always #10 clk = ~clk;

  tblrd_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_dest(req_dest), .tblp(tblp), .pc(pc),
    .pm_rd_en(pm_rd_en), .pm_addr(pm_addr), .pm_rdata(pm_rdata),
    .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .busy(busy), .tblh(tblh)
  );

  function automatic int romw(input int a);
    return ((a * 40503) ^ 16'hA5C3) & 16'hFFFF;
  endfunction

  always @(posedge clk) if (pm_rd_en) pm_rdata <= 16'(romw(int'(pm_addr)));

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(m_st == 0 && !rst_n ? "R7 busy" : "R3 busy", int'(busy), int'(m_st == 1));
    chk("R3 pm_rd_en", int'(pm_rd_en), int'(m_st == 1));
    chk("R8 req_ready", int'(req_ready), int'(m_st != 1));
    if (m_st == 1) chk("R1 R2 R9 pm_addr", int'(pm_addr), m_addr);
    chk("R4 dm_we", int'(dm_we), int'(m_st == 2));
    if (m_st == 2) begin
      chk("R4 dm_addr", int'(dm_addr), m_dest);
      chk("R4 dm_wdata", int'(dm_wdata), romw(m_addr) & 8'hFF);
    end
    chk("R5 R6 tblh", int'(tblh), m_tblh);
  endtask

  // one cycle: compare outputs, drive inputs, advance the reference
  task automatic step(input bit v, input bit md, input int tp, input int p, input int ds, input bit rs);
    @(negedge clk);
    compare();
    rst_n = rs; req_valid = v; req_mode = md;
    tblp = 8'(tp); pc = 11'(p); req_dest = 7'(ds);
    if (!rs) begin
      m_st = 0; m_addr = 0; m_dest = 0; m_tblh = 0;
    end else begin
      bit acc = v && (m_st != 1);
      if (m_st == 2) m_tblh = (romw(m_addr) >> 8) & 8'hFF;
      if (acc) begin
        m_addr = md ? (11'h700 | (tp & 8'hFF)) : ((p & 11'h700) | (tp & 8'hFF));
        m_dest = ds & 7'h7F;
        m_st = 1;
      end else if (m_st == 1) m_st = 2;
      else m_st = 0;
    end
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h7FFFFF;
  endfunction

  initial begin
    // R7: reset state
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    // R1: current page single read
    step(1, 0, 8'h3C, 11'h2A5, 7'h11, 1);
    step(0, 0, 8'hFF, 11'h7FF, 7'h7F, 1); // R9: inputs change in fetch
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    // R2: last page single read
    step(1, 1, 8'h81, 11'h0C2, 7'h22, 1);
    step(1, 0, 8'h01, 11'h100, 7'h33, 1);  // R6: request while busy ignored
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    // R8: back-to-back stream
    for (int i = 0; i < 8; i++) step(1, i[0], i * 29, i * 211, i + 5, 1);
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    // pseudo-random mix
    for (int i = 0; i < 600; i++) begin
      int r = rnd();
      step(r[0] | r[1], r[2], rnd(), rnd(), rnd(), (r[9:4] != 0));
    end
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule